// File: doc/BRIEF.md
# Capture Time Base with Selectable Sync Reload

This block is the free-running time base that capture channels in a motor-control PWM unit sample when they latch an edge. It holds a 32-bit counter that advances by one on every clock cycle while its run bit is set. The counter is exported on `count_o` for the capture logic to read.

A sync event reloads the counter from a phase register that software can write. The event can come from one of three single-cycle pulses produced by the PWM timers, or from one of three asynchronous external sync lines. A numbered select field picks the source, and a sync-enable bit gates hardware events. Software can also force a reload by writing a self-clearing strobe bit. This strobe works whether or not hardware sync is enabled.

Software reaches the block through a simple register-write port with a combinational read-back. Address 0 is the control word and address 1 is the phase value.

Top module: `cap_timebase`

## Requirements
- R1: After reset, `count_o` is 0, the control word reads 0 and the phase register reads 0.
- R2: While control bit 0 (run) is set and no reload occurs, `count_o` rises by exactly one per clock. While run is clear and no reload occurs, `count_o` holds.
- R3: The counter wraps from 0xFFFFFFFF to 0x00000000.
- R4: A write to address 1 stores all 32 bits of the phase value, and address 1 reads back that value. A write to address 0 stores run (bit 0), sync enable (bit 1) and the source select (bits 4:2). Address 0 reads back those five bits, and bits 31:5 always read 0.
- R5: With sync enable set, select values 1, 2 and 3 pick PWM timer pulses `tmr_sync_i[0]`, `[1]` and `[2]`. A selected pulse high before a clock edge loads the phase value at that edge. Pulses on unselected sources have no effect.
- R6: With sync enable set, select values 4, 5 and 6 pick `ext_sync_i[0]`, `[1]` and `[2]`. Each external line passes through two flops, and only a rising edge of the synchronized level is an event. The load lands on the third clock edge after the input goes high. A line that stays high causes no further reload.
- R7: Select values 0 and 7 pick no hardware source, so no timer pulse or external edge reloads the counter.
- R8: With sync enable clear, no hardware source reloads the counter, whatever the select value.
- R9: Writing address 0 with bit 5 set loads the phase value into the counter at that same write edge. This happens even when sync enable and run are both clear. Bit 5 is not stored and always reads 0.
- R10: When a reload and an increment fall on the same cycle, the reload wins, and `count_o` equals the phase value rather than phase plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counter and registers advance on its rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control word, 1 phase value |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 control word, 1 phase value |
| rd_data | output | 32 | Combinational read-back of the addressed register |
| tmr_sync_i | input | 3 | Single-cycle sync pulses from the three PWM timers |
| ext_sync_i | input | 3 | Asynchronous external sync lines |
| count_o | output | 32 | Current time-base count |

## Verification
A wrong select decode shows up at once as a reload from the wrong source, or as a missing reload. The count then differs from the phase value at the first sample after the event edge, so the bench sweeps every select value against every source. A synchronizer with the wrong depth or wrong edge logic moves the reload by a cycle, or repeats it while the line stays high. This is caught three edges after the input rises, and again three cycles later. Errors in increment, hold, wrap or load priority change `count_o` on the very next edge, so the bench compares the count against its own arithmetic cycle by cycle.

// File: rtl/cap_timebase_pkg.sv
package cap_timebase_pkg;
  // control word field positions
  localparam int unsigned CTL_RUN      = 0;
  localparam int unsigned CTL_SYNC_EN  = 1;
  localparam int unsigned CTL_SEL_LSB  = 2;
  localparam int unsigned CTL_SW_SYNC  = 5;

  typedef enum logic {
    REG_CTL   = 1'b0,
    REG_PHASE = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/cap_ext_sync.sv
module cap_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];

  assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cap_sync_select.sv
module cap_sync_select #(
  parameter int unsigned N_SRC = 6,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o
);
  function automatic logic pick(input logic [N_SRC-1:0] v, input logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (s == SEL_W'(i + 1)) r = v[i];
    return r;
  endfunction

  assign evt_o = pick(src_i, sel_i);

  assert_no_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_i == '0) || (int'(sel_i) > N_SRC)) |-> !evt_o);
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] phase_i,
  output logic [W-1:0] cnt_o
);
  function automatic logic [W-1:0] step(input logic [W-1:0] cur,
                                        input logic [W-1:0] ph,
                                        input logic ld, input logic en);
    if (ld)      return ph;
    else if (en) return cur + 1'b1;
    else         return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= step(cnt_o, phase_i, load_i, run_i);
  end

  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_o));
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_o == $past(phase_i));
endmodule

// File: rtl/cap_timebase.sv
module cap_timebase
  import cap_timebase_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned N_TMR       = 3,
  parameter int unsigned N_EXT       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_addr,
  input  logic [CNT_W-1:0]        wr_data,
  input  logic                    rd_addr,
  output logic [CNT_W-1:0]        rd_data,
  input  logic [N_TMR-1:0]        tmr_sync_i,
  input  logic [N_EXT-1:0]        ext_sync_i,
  output logic [CNT_W-1:0]        count_o
);
  localparam int unsigned N_SRC = N_TMR + N_EXT;
  localparam int unsigned SEL_W = $clog2(N_SRC + 1);

  logic             run_q, sync_en_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] phase_q;

  // named internal events
  logic             ctl_wr, phase_wr, sw_sync, hw_evt, hw_load, load;
  logic [N_EXT-1:0] ext_rise;

  assign ctl_wr   = wr_en && (reg_addr_e'(wr_addr) == REG_CTL);
  assign phase_wr = wr_en && (reg_addr_e'(wr_addr) == REG_PHASE);
  assign sw_sync  = ctl_wr && wr_data[CTL_SW_SYNC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      sync_en_q <= 1'b0;
      sel_q     <= '0;
      phase_q   <= '0;
    end else begin
      if (ctl_wr) begin
        run_q     <= wr_data[CTL_RUN];
        sync_en_q <= wr_data[CTL_SYNC_EN];
        sel_q     <= wr_data[CTL_SEL_LSB +: SEL_W];
      end
      if (phase_wr) phase_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (reg_addr_e'(rd_addr) == REG_PHASE) begin
      rd_data = phase_q;
    end else begin
      rd_data[CTL_RUN]                 = run_q;
      rd_data[CTL_SYNC_EN]             = sync_en_q;
      rd_data[CTL_SEL_LSB +: SEL_W]    = sel_q;
    end
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    cap_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ext_sync_i[g]), .rise_o(ext_rise[g])
    );
  end

  cap_sync_select #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .src_i({ext_rise, tmr_sync_i}),
    .sel_i(sel_q), .evt_o(hw_evt)
  );

  assign hw_load = sync_en_q & hw_evt;
  assign load    = hw_load | sw_sync;

  cap_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .load_i(load),
    .phase_i(phase_q), .cnt_o(count_o)
  );

  assert_sw_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sync |=> count_o == $past(phase_q));
  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en_q && !sw_sync && !run_q) |=> $stable(count_o));
endmodule

// File: tb/sim_cap_timebase.sv
module sim_cap_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic [2:0]  tmr_sync_i = '0;
  logic [2:0]  ext_sync_i = '0;
  logic [31:0] count_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cap_timebase u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tmr_sync_i(tmr_sync_i), .ext_sync_i(ext_sync_i), .count_o(count_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_ne(input string tag, input logic [31:0] act, input logic [31:0] bad);
    n_chk++;
    if (act === bad) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=not %h", tag, act, bad);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input int sel, input bit sen, input bit run, input bit sw);
    return (32'(sel) << 2) | (32'(sen) << 1) | 32'(run) | (32'(sw) << 5);
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] c, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count_o, 32'h0);
    rd_addr = 1'b0; #0; check("R1 ctl", rd_data, 32'h0);
    rd_addr = 1'b1; #1; check("R1 phase", rd_data, 32'h0);

    // R4 readback
    wr(1'b1, 32'hA5C3_0F1E);
    rd_addr = 1'b1; #1; check("R4 phase", rd_data, 32'hA5C3_0F1E);
    wr(1'b0, 32'hFFFF_FFDF);
    rd_addr = 1'b0; #1; check("R4 ctl", rd_data, 32'h0000_001F);

    // R2 hold and increment
    wr(1'b0, ctl(0, 0, 0, 0));
    c = count_o;
    repeat (5) @(negedge clk);
    check("R2 hold", count_o, c);
    wr(1'b0, ctl(0, 0, 1, 0));
    c = count_o;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      check("R2 inc", count_o, c + 32'(k));
    end

    // R9 software sync with sync and run clear
    wr(1'b0, ctl(0, 0, 0, 0));
    wr(1'b1, 32'h1234_5678);
    wr(1'b0, ctl(0, 0, 0, 1));
    check("R9 sw load", count_o, 32'h1234_5678);
    rd_addr = 1'b0; #1; check("R9 sw bit reads 0", rd_data, 32'h0);
    repeat (3) @(negedge clk);
    check("R9 hold after load", count_o, 32'h1234_5678);

    // R10 + R3: sw load with run set, then wrap
    wr(1'b1, 32'hFFFF_FFFE);
    wr(1'b0, ctl(0, 0, 1, 1));
    check("R10 load wins", count_o, 32'hFFFF_FFFE);
    @(negedge clk); check("R3 pre", count_o, 32'hFFFF_FFFF);
    @(negedge clk); check("R3 wrap", count_o, 32'h0);
    @(negedge clk); check("R3 post", count_o, 32'h1);

    // R5 R6 R7 sweep: every select against every source
    for (int s = 0; s < 8; s++) begin
      for (int src = 0; src < 6; src++) begin
        bit hit;
        p = 32'h4000_0000 + (32'(s) << 12) + (32'(src) << 8);
        hit = (s == src + 1);
        wr(1'b1, p);
        wr(1'b0, ctl(s, 1, 1, 0));
        if (src < 3) begin
          tmr_sync_i[src] = 1'b1;
          @(negedge clk);
          tmr_sync_i = '0;
          if (hit) check("R5 R10 tmr load", count_o, p);
          else if (s == 0 || s == 7) check_ne("R7 no source", count_o, p);
          else check_ne("R5 unselected", count_o, p);
        end else begin
          ext_sync_i[src-3] = 1'b1;
          repeat (2) @(negedge clk);
          check_ne("R6 not before third edge", count_o, p);
          @(negedge clk);
          if (hit) begin
            check("R6 ext load", count_o, p);
            repeat (3) @(negedge clk);
            check("R6 level no reload", count_o, p + 32'd3);
          end else if (s == 0 || s == 7) check_ne("R7 no source", count_o, p);
          else check_ne("R6 unselected", count_o, p);
          ext_sync_i = '0;
          repeat (4) @(negedge clk);
        end
      end
    end

    // R8 sync enable clear blocks hardware sources
    for (int src = 0; src < 6; src++) begin
      p = 32'h7000_0000 + (32'(src) << 8);
      wr(1'b1, p);
      wr(1'b0, ctl(src + 1, 0, 0, 0));
      c = count_o;
      if (src < 3) begin
        tmr_sync_i[src] = 1'b1;
        @(negedge clk);
        tmr_sync_i = '0;
      end else begin
        ext_sync_i[src-3] = 1'b1;
        repeat (4) @(negedge clk);
        ext_sync_i = '0;
        repeat (3) @(negedge clk);
      end
      check("R8 gated", count_o, c);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule